// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block turns a command word written by software into a single request toward an SD card, then collects the card's answer. Software first writes a 32-bit argument and then a command word whose top bit asks for issue. The sequencer places the command index and argument on an abstract request port, waits for the card's reply and unpacks a 4-byte or 16-byte response into four 32-bit response words. It then emits a single-cycle event: command done, or no response. Commands that only retune the card clock never reach the card bus, but they still report completion.

The block also handles the stop command that ends an open-ended transfer. When the current command word has its auto-stop bit set and the data path reports that the transfer has finished, the sequencer sends index 12 with a zero argument. This stop reuses the response settings of the user command. The stored command word and argument stay as software wrote them, and a stop-done event follows. The physical CMD line, CRC generation and the card itself are outside the block.

Top module: `sd_cmd_seq`

## Requirements
- R1: After reset, busy, req_valid and all three event outputs are low, and cmd_word, cmd_arg and the four response words read zero.
- R2: A write to cmd_wdata while not busy stores the word in cmd_word. Bit 31 (load) always reads back as 0. A word with bit 31 clear raises no request and no event.
- R3: A loaded word with bit 21 (clock change) set places no request on the card port. It pulses evt_cmd_done in the cycle after the write and leaves busy low.
- R4: Any other loaded word raises req_valid for exactly one cycle, one cycle after the write. req_index carries bits 5:0 of the word and req_arg carries cmd_arg.
- R5: When bit 6 (response expected) is set and bit 7 (long) is clear, a 4-byte reply fills resp_w0 with byte 0 as its most significant byte. resp_w1 to resp_w3 are cleared. Byte i of rsp_data sits at bits 8i+7:8i.
- R6: When bits 6 and 7 are both set, a 16-byte reply fills resp_w0 with bytes 12..15, resp_w1 with bytes 8..11, resp_w2 with bytes 4..7 and resp_w3 with bytes 0..3. In each word the lowest-numbered byte is the most significant.
- R7: If the card reports an error, or if a response is expected and rsp_len is not 4 (short) or 16 (long), evt_no_rsp pulses in place of evt_cmd_done. The response words keep their previous values.
- R8: With bit 12 (auto-stop) of cmd_word set, an xfer_done pulse causes a request with index 12 and argument 0 once the sequencer is idle. Its reply then raises evt_cmd_done or evt_no_rsp together with evt_stop_done. cmd_word and cmd_arg are unchanged afterwards.
- R9: busy is high from the accepted load until the reply, and while a stop is pending or outstanding. Command and argument writes during that time are ignored: cmd_word and cmd_arg do not change and no extra request appears.
- R10: Every event output is a one-cycle pulse that appears in the cycle after the reply is sampled. evt_cmd_done and evt_no_rsp are never high together.
- R11: xfer_done with bit 12 of cmd_word clear, and rsp_valid while idle, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument to write |
| xfer_done | input | 1 | Pulse: data transfer count reached zero |
| req_valid | output | 1 | One-cycle card request strobe |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_valid | input | 1 | Card reply strobe |
| rsp_err | input | 1 | Card reports failure |
| rsp_len | input | 5 | Reply length in bytes |
| rsp_data | input | 128 | Reply bytes, byte i at bits 8i+7:8i |
| busy | output | 1 | Command or stop in flight or pending |
| cmd_word | output | 32 | Stored command word |
| cmd_arg | output | 32 | Stored argument |
| resp_w0 | output | 32 | Response word 0 |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 |
| evt_cmd_done | output | 1 | Pulse: command completed |
| evt_no_rsp | output | 1 | Pulse: missing or malformed response |
| evt_stop_done | output | 1 | Pulse: automatic stop finished |

## Verification
The hardest situation to reach is the automatic stop. It needs a completed user command with the auto-stop bit set, then an xfer_done pulse, and then a second reply answering index 12. The bench loads such a command, answers it, pulses xfer_done and waits for the stop request. It checks index 12 with a zero argument, answers the stop with a distinct payload, and then reads back that cmd_word and cmd_arg still hold the user's values. The ignored-write cases are reached by writing while a reply is held back on purpose.

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq #(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int LEN_W    = 5,
  parameter int STOP_IDX = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [31:0]         cmd_wdata,
  input  logic                arg_wr,
  input  logic [ARG_W-1:0]    arg_wdata,
  input  logic                xfer_done,
  output logic                req_valid,
  output logic [IDX_W-1:0]    req_index,
  output logic [ARG_W-1:0]    req_arg,
  input  logic                rsp_valid,
  input  logic                rsp_err,
  input  logic [LEN_W-1:0]    rsp_len,
  input  logic [127:0]        rsp_data,
  output logic                busy,
  output logic [31:0]         cmd_word,
  output logic [ARG_W-1:0]    cmd_arg,
  output logic [31:0]         resp_w0,
  output logic [31:0]         resp_w1,
  output logic [31:0]         resp_w2,
  output logic [31:0]         resp_w3,
  output logic                evt_cmd_done,
  output logic                evt_no_rsp,
  output logic                evt_stop_done
);
  localparam int B_LOAD  = 31;
  localparam int B_CLK   = 21;
  localparam int B_ASTOP = 12;
  localparam int B_LONG  = 7;
  localparam int B_RESP  = 6;
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(16);
  localparam logic [31:0] LOAD_CLR = ~(32'h1 << B_LOAD);

  typedef enum logic [1:0] {S_IDLE, S_USER, S_STOP} st_t;
  st_t st;

  logic [31:0]      cmd_q;
  logic [ARG_W-1:0] arg_q;
  logic             stop_pend;

  function automatic logic [31:0] be_word(input logic [127:0] d, input int k);
    return {d[8*k +: 8], d[8*(k+1) +: 8], d[8*(k+2) +: 8], d[8*(k+3) +: 8]};
  endfunction

  wire resp_exp = cmd_q[B_RESP];
  wire resp_long = cmd_q[B_LONG];
  wire len_ok = resp_long ? (rsp_len == LEN_LONG) : (rsp_len == LEN_SHORT);
  wire rsp_ok = !rsp_err && (!resp_exp || len_ok);
  wire in_flight = (st != S_IDLE);

  assign busy     = in_flight || stop_pend;
  assign cmd_word = cmd_q;
  assign cmd_arg  = arg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cmd_q         <= '0;
      arg_q         <= '0;
      stop_pend     <= 1'b0;
      req_valid     <= 1'b0;
      req_index     <= '0;
      req_arg       <= '0;
      resp_w0       <= '0;
      resp_w1       <= '0;
      resp_w2       <= '0;
      resp_w3       <= '0;
      evt_cmd_done  <= 1'b0;
      evt_no_rsp    <= 1'b0;
      evt_stop_done <= 1'b0;
    end else begin
      req_valid     <= 1'b0;
      evt_cmd_done  <= 1'b0;
      evt_no_rsp    <= 1'b0;
      evt_stop_done <= 1'b0;

      if (xfer_done && cmd_q[B_ASTOP] && !stop_pend)
        stop_pend <= 1'b1;

      case (st)
        S_IDLE: begin
          if (stop_pend) begin
            stop_pend <= 1'b0;
            if (cmd_q[B_CLK]) begin
              evt_cmd_done  <= 1'b1;
              evt_stop_done <= 1'b1;
            end else begin
              st        <= S_STOP;
              req_valid <= 1'b1;
              req_index <= IDX_W'(STOP_IDX);
              req_arg   <= '0;
            end
          end else begin
            if (cmd_wr) begin
              cmd_q <= cmd_wdata & LOAD_CLR;
              if (cmd_wdata[B_LOAD]) begin
                if (cmd_wdata[B_CLK]) begin
                  evt_cmd_done <= 1'b1;
                end else begin
                  st        <= S_USER;
                  req_valid <= 1'b1;
                  req_index <= cmd_wdata[IDX_W-1:0];
                  req_arg   <= arg_q;
                end
              end
            end
            if (arg_wr)
              arg_q <= arg_wdata;
          end
        end
        S_USER, S_STOP: begin
          if (rsp_valid) begin
            st <= S_IDLE;
            if (st == S_STOP)
              evt_stop_done <= 1'b1;
            if (rsp_ok) begin
              evt_cmd_done <= 1'b1;
              if (resp_exp) begin
                if (resp_long) begin
                  resp_w0 <= be_word(rsp_data, 12);
                  resp_w1 <= be_word(rsp_data, 8);
                  resp_w2 <= be_word(rsp_data, 4);
                  resp_w3 <= be_word(rsp_data, 0);
                end else begin
                  resp_w0 <= be_word(rsp_data, 0);
                  resp_w1 <= '0;
                  resp_w2 <= '0;
                  resp_w3 <= '0;
                end
              end
            end else begin
              evt_no_rsp <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_LOAD_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cmd_word[B_LOAD]); // R2
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> !req_valid); // R4
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> busy); // R9
  AST_STOP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && st == S_STOP) |-> (req_index == IDX_W'(STOP_IDX) && req_arg == '0)); // R8
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_word)); // R9
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(evt_cmd_done && evt_no_rsp)); // R10
  AST_STOP_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop_done |-> (evt_cmd_done || evt_no_rsp)); // R8
endmodule

// File: tb/tb_sd_cmd_seq.sv
module tb_sd_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0, arg_wr = 1'b0, xfer_done = 1'b0;
  logic [31:0] cmd_wdata = '0, arg_wdata = '0;
  logic rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [4:0] rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic req_valid, busy, evt_cmd_done, evt_no_rsp, evt_stop_done;
  logic [5:0] req_index;
  logic [31:0] req_arg, cmd_word, cmd_arg, resp_w0, resp_w1, resp_w2, resp_w3;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sd_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .arg_wr(arg_wr), .arg_wdata(arg_wdata), .xfer_done(xfer_done),
    .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_len(rsp_len), .rsp_data(rsp_data),
    .busy(busy), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
    .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3),
    .evt_cmd_done(evt_cmd_done), .evt_no_rsp(evt_no_rsp), .evt_stop_done(evt_stop_done));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_evt(input string tag, input logic d, input logic n, input logic s);
    chk({tag, " evt_cmd_done"}, {31'b0, evt_cmd_done}, {31'b0, d});
    chk({tag, " evt_no_rsp"}, {31'b0, evt_no_rsp}, {31'b0, n});
    chk({tag, " evt_stop_done"}, {31'b0, evt_stop_done}, {31'b0, s});
  endtask

  task automatic put_arg(input logic [31:0] a);
    @(negedge clk); arg_wr = 1'b1; arg_wdata = a;
    @(negedge clk); arg_wr = 1'b0;
  endtask

  task automatic put_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic reply(input logic err, input logic [4:0] len, input logic [7:0] base);
    for (int i = 0; i < 16; i++) rsp_data[8*i +: 8] = base + 8'(i);
    rsp_valid = 1'b1; rsp_err = err; rsp_len = len;
    @(negedge clk); rsp_valid = 1'b0; rsp_err = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 req_valid", {31'b0, req_valid}, 0);
    chk("R1 cmd_word", cmd_word, 0);
    chk("R1 cmd_arg", cmd_arg, 0);
    chk("R1 resp_w0", resp_w0, 0);
    chk("R1 resp_w3", resp_w3, 0);
    chk_evt("R1", 0, 0, 0);
  endtask

  task automatic t_no_load();
    put_cmd(32'h0000_0045);
    chk("R2 stored", cmd_word, 32'h0000_0045);
    chk("R2 no req", {31'b0, req_valid}, 0);
    chk("R2 not busy", {31'b0, busy}, 0);
    chk_evt("R2", 0, 0, 0);
  endtask

  task automatic t_long();
    put_arg(32'hCAFE_0001);
    put_cmd(32'h8000_00C2);
    chk("R2 load cleared", cmd_word, 32'h0000_00C2);
    chk("R4 req_valid", {31'b0, req_valid}, 1);
    chk("R4 index", {26'b0, req_index}, 2);
    chk("R4 arg", req_arg, 32'hCAFE_0001);
    chk("R9 busy", {31'b0, busy}, 1);
    @(negedge clk);
    chk("R4 one cycle", {31'b0, req_valid}, 0);
    reply(1'b0, 5'd16, 8'h01);
    chk_evt("R6", 1, 0, 0);
    chk("R6 w0", resp_w0, 32'h0D0E_0F10);
    chk("R6 w1", resp_w1, 32'h090A_0B0C);
    chk("R6 w2", resp_w2, 32'h0506_0708);
    chk("R6 w3", resp_w3, 32'h0102_0304);
    chk("R9 idle", {31'b0, busy}, 0);
    @(negedge clk);
    chk_evt("R10 pulse", 0, 0, 0);
  endtask

  task automatic t_short();
    put_arg(32'hDEAD_BEEF);
    put_cmd(32'h8000_0051);
    chk("R4 index", {26'b0, req_index}, 17);
    chk("R4 arg", req_arg, 32'hDEAD_BEEF);
    reply(1'b0, 5'd4, 8'h11);
    chk_evt("R5", 1, 0, 0);
    chk("R5 w0", resp_w0, 32'h1112_1314);
    chk("R5 w1", resp_w1, 0);
    chk("R5 w2", resp_w2, 0);
    chk("R5 w3", resp_w3, 0);
  endtask

  task automatic t_bad();
    put_cmd(32'h8000_0051);
    reply(1'b0, 5'd16, 8'h40);
    chk_evt("R7 len", 0, 1, 0);
    chk("R7 w0 kept", resp_w0, 32'h1112_1314);
    put_cmd(32'h8000_00C3);
    reply(1'b1, 5'd16, 8'h50);
    chk_evt("R7 err", 0, 1, 0);
    chk("R7 w3 kept", resp_w3, 0);
  endtask

  task automatic t_clk_change();
    put_cmd(32'h8020_0000);
    chk("R3 no req", {31'b0, req_valid}, 0);
    chk("R3 not busy", {31'b0, busy}, 0);
    chk_evt("R3", 1, 0, 0);
    @(negedge clk);
    chk_evt("R3 pulse", 0, 0, 0);
  endtask

  task automatic t_busy_ignore();
    put_arg(32'h0000_0777);
    put_cmd(32'h8000_0008);
    put_cmd(32'h8000_0019);
    chk("R9 word kept", cmd_word, 32'h0000_0008);
    chk("R9 no req", {31'b0, req_valid}, 0);
    put_arg(32'h0000_0999);
    chk("R9 arg kept", cmd_arg, 32'h0000_0777);
    reply(1'b0, 5'd0, 8'h00);
    chk_evt("R9 done", 1, 0, 0);
    chk("R11 w0 kept", resp_w0, 32'h1112_1314);
  endtask

  task automatic t_idle_noise();
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    chk("R11 xfer ignored", {31'b0, busy}, 0);
    reply(1'b0, 5'd4, 8'h99);
    chk_evt("R11 idle rsp", 0, 0, 0);
    chk("R11 resp kept", resp_w0, 32'h1112_1314);
  endtask

  task automatic t_auto_stop();
    put_arg(32'h0000_1234);
    put_cmd(32'h8000_1052);
    chk("R4 index", {26'b0, req_index}, 18);
    reply(1'b0, 5'd4, 8'h20);
    chk_evt("R8 user", 1, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    chk("R8 pending busy", {31'b0, busy}, 1);
    chk("R8 not yet", {31'b0, req_valid}, 0);
    @(negedge clk);
    chk("R8 stop req", {31'b0, req_valid}, 1);
    chk("R8 stop index", {26'b0, req_index}, 12);
    chk("R8 stop arg", req_arg, 0);
    reply(1'b0, 5'd4, 8'hAA);
    chk_evt("R8 stop", 1, 0, 1);
    chk("R8 stop resp", resp_w0, 32'hAAAB_ACAD);
    chk("R8 word restored", cmd_word, 32'h0000_1052);
    chk("R8 arg restored", cmd_arg, 32'h0000_1234);
    chk("R8 idle", {31'b0, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_load();
    t_long();
    t_short();
    t_bad();
    t_clk_change();
    t_busy_ignore();
    t_idle_noise();
    t_auto_stop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule